// File: doc/BRIEF.md
# MOESI Snooping Cache Coherence Controller

This block keeps one private cache coherent with its peers on a shared, atomic snooping bus. Each line carries one of five states: Invalid, Shared, Exclusive, Owned or Modified. The Owned state lets a dirty line be shared without first being written back to memory. The cache that holds a line in Owned answers every later read of that line from another cache. It also keeps the duty to write the line back when the line is finally evicted. Memory answers a read only when no cache holds the line in Modified or Owned.

The processor side takes one request at a time: a load or a store of one word. Reads that hit are answered from the local array. Misses, upgrades and write-backs of dirty victims go out as bus transactions. A transaction ends in the cycle its grant is seen, because the bus is atomic. The snoop input carries the transaction that another cache is running on the bus. In that same cycle the block drives a shared-line indication and, when it holds the only current copy, the data that answers the snoop. The bus never grants this cache in a cycle that carries a snoop. The array is direct-mapped, with one word per line.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_req_ready` is high, and `bus_req` and `cpu_resp_valid` are low. A snoop of any address leaves `snp_shared` and `sup_valid` low.
- R2: A load miss issues a bus read (cmd 0). On grant the line is filled from `bus_rdata` and becomes Shared if `bus_shared_in` is high, or Exclusive if it is low. The fill data is returned on `cpu_resp_rdata` with `cpu_resp_valid` in the cycle after the grant.
- R3: A store miss issues a read-exclusive (cmd 1) and leaves the line Modified with the store data. A store to an Exclusive line completes with no bus request and leaves the line Modified. A store is acknowledged by returning the stored word.
- R4: A store to a Shared or Owned line issues an upgrade (cmd 2) and leaves the line Modified. If a snoop invalidates that line while the upgrade waits for its grant, a read-exclusive (cmd 1) is issued instead.
- R5: A snooped read (cmd 0) that hits a Modified line raises `sup_valid` with the line data and moves the line to Owned, with no write to memory. An Owned line keeps supplying data on later snooped reads and stays Owned.
- R6: A snooped read that hits an Exclusive or Shared line raises `snp_shared` but not `sup_valid`. An Exclusive line moves to Shared.
- R7: A snooped read-exclusive that hits a Modified or Owned line supplies the line data and moves the line to Invalid, without a write-back. A snooped read-exclusive on Exclusive or Shared, or a snooped upgrade on any valid line, moves the line to Invalid with no supply. A snoop that misses leaves `snp_shared` low.
- R8: A miss whose victim is Modified or Owned first issues a write-back (cmd 3) of the victim's address and data, then the fill. A victim in Exclusive or Shared is dropped silently.
- R9: If a snoop invalidates a dirty victim while its write-back waits for the bus, the write-back is abandoned and the fill is issued directly.
- R10: In any cycle with `snp_valid` high, `cpu_req_ready` is low. A request held across that cycle is accepted afterwards and sees the line state the snoop left.
- R11: A load that hits returns the line data in the cycle after acceptance, with no bus request.
- R12: A snooped write-back (cmd 3) leaves the line state unchanged and supplies no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Request accepted at this edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load data or stored word |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill data for read and read-exclusive |
| bus_shared_in | input | 1 | Another cache holds the line being read |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped line |
| sup_valid | output | 1 | This cache supplies the snooped line's data |
| sup_data | output | DATA_W | Supplied data |

## Verification
A snoop and a processor request can arrive in the same cycle on the same line. A snoop can also land on the line of a request that has been accepted but is still waiting for the bus. The bench raises a store to an Exclusive line together with a snooped read of that line. It expects the request to be refused in that cycle, the shared line to be raised without data, and the store, once taken, to issue an upgrade instead of completing silently. It also invalidates the target of a waiting upgrade and the dirty victim of a waiting write-back. It then checks that the pending command turns into a read-exclusive or disappears, and that memory never receives the stale victim.

// File: rtl/moesi_snoop_ctrl.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              sup_valid,
  output logic [DATA_W-1:0] sup_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  typedef enum logic [2:0] {L_I, L_S, L_E, L_O, L_M} lst_t;
  typedef enum logic [1:0] {P_IDLE, P_WB, P_FILL, P_UPG} ph_t;

  lst_t              lst  [SETS];
  logic [TAG_W-1:0]  ltag [SETS];
  logic [DATA_W-1:0] ldat [SETS];

  ph_t               ph;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              rsp_v;
  logic [DATA_W-1:0] rsp_d;

  logic [IDX_W-1:0] c_idx, p_idx, s_idx;
  logic [TAG_W-1:0] c_tag, p_tag, s_tag;
  lst_t             c_st, p_st, s_st;
  logic             c_hit, c_dirty, p_hit, v_dirty, s_hit, acc;

  assign c_idx = cpu_req_addr[IDX_W-1:0];
  assign c_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign p_idx = req_addr[IDX_W-1:0];
  assign p_tag = req_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  assign c_st    = lst[c_idx];
  assign p_st    = lst[p_idx];
  assign s_st    = lst[s_idx];
  assign c_hit   = (c_st != L_I) && (ltag[c_idx] == c_tag);
  assign c_dirty = (c_st == L_M) || (c_st == L_O);
  assign p_hit   = (p_st != L_I) && (ltag[p_idx] == p_tag);
  assign v_dirty = (p_st == L_M) || (p_st == L_O);
  assign s_hit   = snp_valid && (s_st != L_I) && (ltag[s_idx] == s_tag);

  assign snp_shared = s_hit;
  assign sup_valid  = s_hit && ((s_st == L_M) || (s_st == L_O)) &&
                      ((snp_cmd == C_RD) || (snp_cmd == C_RDX));
  assign sup_data   = ldat[s_idx];

  assign cpu_req_ready  = (ph == P_IDLE) && !snp_valid;
  assign acc            = cpu_req_valid && cpu_req_ready;
  assign cpu_resp_valid = rsp_v;
  assign cpu_resp_rdata = rsp_d;

  assign bus_req   = (ph == P_FILL) || (ph == P_UPG) || ((ph == P_WB) && v_dirty);
  assign bus_addr  = (ph == P_WB) ? {ltag[p_idx], p_idx} : req_addr;
  assign bus_wdata = ldat[p_idx];

  always_comb begin
    case (ph)
      P_WB:    bus_cmd = C_WB;
      P_FILL:  bus_cmd = req_wr ? C_RDX : C_RD;
      P_UPG:   bus_cmd = p_hit ? C_UPG : C_RDX;
      default: bus_cmd = C_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= P_IDLE;
      req_wr   <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
      rsp_v    <= 1'b0;
      rsp_d    <= '0;
      for (int i = 0; i < SETS; i++) begin
        lst[i]  <= L_I;
        ltag[i] <= '0;
        ldat[i] <= '0;
      end
    end else begin
      rsp_v <= 1'b0;

      if (s_hit) begin
        case (snp_cmd)
          C_RD: begin
            if (s_st == L_M) lst[s_idx] <= L_O;
            if (s_st == L_E) lst[s_idx] <= L_S;
          end
          C_RDX, C_UPG: lst[s_idx] <= L_I;
          default: ;
        endcase
      end

      case (ph)
        P_IDLE: if (acc) begin
          req_wr   <= cpu_req_write;
          req_addr <= cpu_req_addr;
          req_data <= cpu_req_wdata;
          if (c_hit && !cpu_req_write) begin
            rsp_v <= 1'b1;
            rsp_d <= ldat[c_idx];
          end else if (c_hit && ((c_st == L_M) || (c_st == L_E))) begin
            lst[c_idx]  <= L_M;
            ldat[c_idx] <= cpu_req_wdata;
            rsp_v       <= 1'b1;
            rsp_d       <= cpu_req_wdata;
          end else if (c_hit) begin
            ph <= P_UPG;
          end else if (c_dirty) begin
            ph <= P_WB;
          end else begin
            ph <= P_FILL;
          end
        end
        P_WB: begin
          if (!v_dirty) begin
            ph <= P_FILL;
          end else if (bus_gnt) begin
            lst[p_idx] <= L_I;
            ph         <= P_FILL;
          end
        end
        P_FILL: if (bus_gnt) begin
          ltag[p_idx] <= p_tag;
          rsp_v       <= 1'b1;
          if (req_wr) begin
            lst[p_idx]  <= L_M;
            ldat[p_idx] <= req_data;
            rsp_d       <= req_data;
          end else begin
            lst[p_idx]  <= bus_shared_in ? L_S : L_E;
            ldat[p_idx] <= bus_rdata;
            rsp_d       <= bus_rdata;
          end
          ph <= P_IDLE;
        end
        P_UPG: if (bus_gnt) begin
          ltag[p_idx] <= p_tag;
          lst[p_idx]  <= L_M;
          ldat[p_idx] <= req_data;
          rsp_v       <= 1'b1;
          rsp_d       <= req_data;
          ph          <= P_IDLE;
        end
        default: ph <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_ready,
  input logic       cpu_resp_valid,
  input logic       bus_req,
  input logic [1:0] bus_cmd,
  input logic       bus_gnt,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_shared,
  input logic       sup_valid
);
  // R10
  snoop_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);

  // R5
  supply_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |-> (snp_shared && ((snp_cmd == 2'd0) || (snp_cmd == 2'd1))));

  // R1
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready);

  // R2
  fill_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && (bus_cmd != 2'd3)) |=> cpu_resp_valid);

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && (bus_cmd == 2'd3)) |=> (bus_req && (bus_cmd != 2'd3)));

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd)));
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk u_chk (.*);

// File: tb/moesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_test;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SN = 2'd2;
  localparam logic [1:0] B_RD = 2'd0, B_RDX = 2'd1, B_UPG = 2'd2, B_WB = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  cmd;
    logic [7:0]  addr;
    logic [15:0] data;
    logic        sh;
    logic [15:0] exp;
    logic [1:0]  nb;
    logic [1:0]  c0;
    logic [1:0]  c1;
    logic        sup;
    logic        shr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{K_RD, B_RD,  8'h04, 16'h0000, 1'b0, 16'hA004, 2'd1, B_RD,  B_RD, 1'b0, 1'b0, 4'd2},  // R2
    '{K_WR, B_RD,  8'h04, 16'h1111, 1'b0, 16'h1111, 2'd0, B_RD,  B_RD, 1'b0, 1'b0, 4'd3},  // R3
    '{K_SN, B_RD,  8'h04, 16'h0000, 1'b0, 16'h1111, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd5},  // R5
    '{K_SN, B_RD,  8'h04, 16'h0000, 1'b0, 16'h1111, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd5},
    '{K_RD, B_RD,  8'h04, 16'h0000, 1'b0, 16'h1111, 2'd0, B_RD,  B_RD, 1'b0, 1'b0, 4'd11}, // R11
    '{K_WR, B_RD,  8'h04, 16'h2222, 1'b0, 16'h2222, 2'd1, B_UPG, B_RD, 1'b0, 1'b0, 4'd4},  // R4
    '{K_SN, B_RDX, 8'h04, 16'h0000, 1'b0, 16'h2222, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd7},  // R7
    '{K_RD, B_RD,  8'h04, 16'h0000, 1'b1, 16'hA004, 2'd1, B_RD,  B_RD, 1'b0, 1'b0, 4'd7},
    '{K_SN, B_RD,  8'h04, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b1, 4'd6},  // R6
    '{K_WR, B_RD,  8'h04, 16'h3333, 1'b0, 16'h3333, 2'd1, B_UPG, B_RD, 1'b0, 1'b0, 4'd4},
    '{K_RD, B_RD,  8'h08, 16'h3333, 1'b0, 16'hA008, 2'd2, B_WB,  B_RD, 1'b0, 1'b0, 4'd8},  // R8
    '{K_SN, B_RD,  8'h08, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b1, 4'd6},
    '{K_WR, B_RD,  8'h08, 16'h4444, 1'b0, 16'h4444, 2'd1, B_UPG, B_RD, 1'b0, 1'b0, 4'd6},
    '{K_RD, B_RD,  8'h04, 16'h4444, 1'b0, 16'h3333, 2'd2, B_WB,  B_RD, 1'b0, 1'b0, 4'd8},
    '{K_RD, B_RD,  8'h08, 16'h0000, 1'b0, 16'h4444, 2'd1, B_RD,  B_RD, 1'b0, 1'b0, 4'd8},
    '{K_SN, B_UPG, 8'h08, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b1, 4'd7},
    '{K_SN, B_RD,  8'h08, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b0, 4'd7},
    '{K_WR, B_RD,  8'h05, 16'h5555, 1'b0, 16'h5555, 2'd1, B_RDX, B_RD, 1'b0, 1'b0, 4'd3},
    '{K_SN, B_RD,  8'h05, 16'h0000, 1'b0, 16'h5555, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd5},
    '{K_RD, B_RD,  8'h06, 16'h0000, 1'b1, 16'hA006, 2'd1, B_RD,  B_RD, 1'b0, 1'b0, 4'd2},
    '{K_SN, B_RDX, 8'h06, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b1, 4'd7},
    '{K_SN, B_WB,  8'h05, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b1, 4'd12}, // R12
    '{K_SN, B_RDX, 8'h05, 16'h0000, 1'b0, 16'h5555, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd12},
    '{K_SN, B_RD,  8'h05, 16'h0000, 1'b0, 16'h0000, 2'd0, B_RD,  B_RD, 1'b0, 1'b0, 4'd7},
    '{K_WR, B_RD,  8'h05, 16'h6666, 1'b0, 16'h6666, 2'd1, B_RDX, B_RD, 1'b0, 1'b0, 4'd3},
    '{K_SN, B_RD,  8'h05, 16'h0000, 1'b0, 16'h6666, 2'd0, B_RD,  B_RD, 1'b1, 1'b1, 4'd5},
    '{K_RD, B_RD,  8'h09, 16'h6666, 1'b0, 16'hA009, 2'd2, B_WB,  B_RD, 1'b0, 1'b0, 4'd8},
    '{K_RD, B_RD,  8'h05, 16'h0000, 1'b0, 16'h6666, 2'd1, B_RD,  B_RD, 1'b0, 1'b0, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [15:0] cpu_resp_rdata;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        bus_shared_in = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_shared, sup_valid;
  logic [15:0] sup_data;

  logic [15:0] mem [256];
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  moesi_snoop_ctrl uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input int req, input logic [15:0] act,
                     input logic [15:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic grant(input logic sh);
    if (bus_cmd == B_WB) mem[bus_addr] = bus_wdata;
    bus_rdata = mem[bus_addr];
    bus_shared_in = sh;
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    #1;
  endtask

  task automatic do_cpu(input logic wr, input logic [7:0] a, input logic [15:0] d,
                        input logic sh, output logic [15:0] rd, output int nb,
                        output logic [1:0] c0, output logic [1:0] c1, output logic [15:0] wbd);
    rd = '0; nb = 0; c0 = '0; c1 = '0; wbd = '0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    for (int k = 0; k < 20; k++) begin
      if (cpu_resp_valid) begin rd = cpu_resp_rdata; break; end
      if (bus_req) begin
        if (nb == 0) c0 = bus_cmd; else c1 = bus_cmd;
        nb++;
        if (bus_cmd == B_WB) wbd = bus_wdata;
        grant(sh);
      end else begin
        @(negedge clk); #1;
      end
    end
  endtask

  task automatic do_snp(input logic [1:0] cmd, input logic [7:0] a,
                        output logic shr, output logic sv, output logic [15:0] sd);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1;
    shr = snp_shared; sv = sup_valid; sd = sup_data;
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
  endtask

  initial begin
    logic [15:0] rd, wbd, sd;
    logic [1:0]  c0, c1;
    logic        shr, sv;
    int          nb;
    vec_t        v;
    for (int a = 0; a < 256; a++) mem[a] = 16'hA000 | 16'(a);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(cpu_req_ready == 1'b1, 1, 16'(cpu_req_ready), 16'd1, "ready after reset");
    chk(bus_req == 1'b0, 1, 16'(bus_req), 16'd0, "bus_req after reset");
    chk(cpu_resp_valid == 1'b0, 1, 16'(cpu_resp_valid), 16'd0, "resp after reset");
    do_snp(B_RD, 8'h04, shr, sv, sd);
    chk(shr == 1'b0 && sv == 1'b0, 1, {14'd0, shr, sv}, 16'd0, "snoop on empty cache");

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v.kind == K_SN) begin
        do_snp(v.cmd, v.addr, shr, sv, sd);
        chk(shr == v.shr, int'(v.req), 16'(shr), 16'(v.shr), "snoop shared");
        chk(sv == v.sup, int'(v.req), 16'(sv), 16'(v.sup), "supply valid");
        if (v.sup) chk(sd == v.exp, int'(v.req), sd, v.exp, "supply data");
      end else begin
        do_cpu(v.kind == K_WR, v.addr, v.data, v.sh, rd, nb, c0, c1, wbd);
        chk(rd == v.exp, int'(v.req), rd, v.exp, "response data");
        chk(nb == int'(v.nb), int'(v.req), 16'(nb), 16'(v.nb), "bus transaction count");
        if (v.nb >= 2'd1) chk(c0 == v.c0, int'(v.req), 16'(c0), 16'(v.c0), "first bus cmd");
        if (v.nb == 2'd2) chk(c1 == v.c1, int'(v.req), 16'(c1), 16'(v.c1), "second bus cmd");
        if (v.nb >= 2'd1 && v.c0 == B_WB) chk(wbd == v.data, int'(v.req), wbd, v.data, "write-back data");
      end
    end

    // R10: snoop and store to an Exclusive line in the same cycle
    do_cpu(1'b0, 8'h07, 16'h0, 1'b0, rd, nb, c0, c1, wbd);
    chk(rd == 16'hA007, 2, rd, 16'hA007, "fill of 07");
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h07; cpu_req_wdata = 16'h7777;
    snp_valid = 1'b1; snp_cmd = B_RD; snp_addr = 8'h07;
    #1;
    chk(cpu_req_ready == 1'b0, 10, 16'(cpu_req_ready), 16'd0, "ready during snoop");
    chk(snp_shared == 1'b1 && sup_valid == 1'b0, 10, {14'd0, snp_shared, sup_valid}, 16'h2, "snoop of E line");
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(cpu_req_ready == 1'b1, 10, 16'(cpu_req_ready), 16'd1, "ready after snoop");
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == B_UPG, 10, {13'd0, bus_req, bus_cmd}, {13'd0, 1'b1, B_UPG}, "store after snoop upgrades");
    grant(1'b0);
    chk(cpu_resp_valid == 1'b1, 10, 16'(cpu_resp_valid), 16'd1, "store completes");

    // R4: upgrade turned into read-exclusive by an intervening invalidation
    do_cpu(1'b0, 8'h06, 16'h0, 1'b1, rd, nb, c0, c1, wbd);
    chk(rd == 16'hA006, 2, rd, 16'hA006, "shared fill of 06");
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h06; cpu_req_wdata = 16'h8888;
    #1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == B_UPG, 4, {13'd0, bus_req, bus_cmd}, {13'd0, 1'b1, B_UPG}, "upgrade requested");
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = B_UPG; snp_addr = 8'h06;
    #1;
    chk(snp_shared == 1'b1, 4, 16'(snp_shared), 16'd1, "invalidating snoop hits");
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == B_RDX, 4, {13'd0, bus_req, bus_cmd}, {13'd0, 1'b1, B_RDX}, "upgrade became read-exclusive");
    grant(1'b0);
    chk(cpu_resp_valid && cpu_resp_rdata == 16'h8888, 4, cpu_resp_rdata, 16'h8888, "store ack");
    do_snp(B_RD, 8'h06, shr, sv, sd);
    chk(sv && sd == 16'h8888, 4, sd, 16'h8888, "line now modified");

    // R9: pending write-back abandoned after victim invalidated
    do_cpu(1'b1, 8'h04, 16'h9999, 1'b0, rd, nb, c0, c1, wbd);
    chk(nb == 1 && c0 == B_RDX, 3, 16'(c0), 16'(B_RDX), "store miss to 04");
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h08;
    #1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == B_WB, 9, {13'd0, bus_req, bus_cmd}, {13'd0, 1'b1, B_WB}, "write-back pending");
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = B_RDX; snp_addr = 8'h04;
    #1;
    chk(sup_valid && sup_data == 16'h9999, 9, sup_data, 16'h9999, "victim supplies");
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) begin
      if (bus_req) break;
      @(negedge clk); #1;
    end
    chk(bus_req && bus_cmd == B_RD && bus_addr == 8'h08, 9, {6'd0, bus_cmd, bus_addr}, {6'd0, B_RD, 8'h08}, "fill without write-back");
    grant(1'b0);
    chk(cpu_resp_valid && cpu_resp_rdata == 16'h4444, 9, cpu_resp_rdata, 16'h4444, "fill data");
    chk(mem[8'h04] == 16'h3333, 9, mem[8'h04], 16'h3333, "memory untouched");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule